// File: doc/BRIEF.md
# Pin Controller with Interrupt Aggregation

This block manages a bank of general-purpose pins from a 32-bit register bus. Software chooses which pins drive, sets or clears the driven values without a read-modify-write, reads back the synchronised pin levels, and arms each pin to raise an interrupt on a level or on an edge of either polarity. All armed pins share one interrupt line.

Each pin input passes through two flip-flops before any logic sees it. An edge-armed pin latches its event into a pending bit that holds until software clears it; a level-armed pin shows its live condition in that bit. A pin reaches the interrupt line only when both its enable bit and its mask bit are set. A build parameter flips the sense of the direction register, so a written 1 means "input" instead of "output".

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is 0, `irq` is 0, and every register reads 0, except that the direction register reads all ones over the pins when `OE_ACTIVE_LOW` is 1.
- R2: A write to offset 0x0C drives high each pin whose data bit is 1; a write to offset 0x10 drives low each pin whose data bit is 1; 0 bits leave pins unchanged. Reading either offset returns the output data.
- R3: The direction register at offset 0x00 is read/write. With `OE_ACTIVE_LOW` = 0 a 1 makes the pin drive (`pin_oe` = 1); with `OE_ACTIVE_LOW` = 1 a 1 makes it an input.
- R4: Offset 0x04 returns the pin inputs after a two-flop synchroniser: a level applied before rising edge k is readable in the data returned at edge k+2 when the read address is presented then.
- R5: Offset 0x18 holds the per-pin trigger kind (1 = level, 0 = edge) and offset 0x1C the polarity (1 = high level or rising edge, 0 = low level or falling edge).
- R6: For an edge-armed pin the pending bit (offset 0x20) sets one cycle after the synchronised input shows the chosen transition and holds until a write of 1 to that bit of offset 0x20; a new edge in the same cycle as that clearing write wins.
- R7: For a level-armed pin the pending bit equals, one cycle later, whether the synchronised input matches the polarity bit; writes to offset 0x20 do not affect it.
- R8: `irq` is registered: it is 1 one cycle after any pin has pending, enable (offset 0x14) and mask (offset 0x24) all set, and 0 otherwise.
- R9: Register bits at and above `NUM_PINS` read 0 and ignore writes; unused word offsets read 0. Address bits 1:0 are ignored.
- R10: Read data is registered: `bus_rdata` after a rising edge holds the register selected by `bus_addr` at that edge, with its value before any write at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output data to the pads |
| pin_oe | output | NUM_PINS | Per-pin drive enable, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
The collision that matters is an edge being latched into a pending bit in the very cycle that software writes 1 to clear that bit. The bench provokes it by counting the synchroniser and detector stages so the clearing write lands at the edge where the detector fires, then reads the pending register and expects the bit still set. A long randomised stretch of writes to every offset, combined with random pin toggling, repeats the same and other overlaps (type changes during a pending edge, mask writes as pending rises), with every output compared each clock against a behavioural model.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_LVL,
    SEL_HI,
    SEL_LO,
    SEL_IEN,
    SEL_KIND,
    SEL_POL,
    SEL_PEND,
    SEL_MSK
  } reg_sel_e;

  // Word offsets (byte address bits 7:2)
  localparam logic [5:0] W_DIR  = 6'h00;
  localparam logic [5:0] W_LVL  = 6'h01;
  localparam logic [5:0] W_HI   = 6'h03;
  localparam logic [5:0] W_LO   = 6'h04;
  localparam logic [5:0] W_IEN  = 6'h05;
  localparam logic [5:0] W_KIND = 6'h06;
  localparam logic [5:0] W_POL  = 6'h07;
  localparam logic [5:0] W_PEND = 6'h08;
  localparam logic [5:0] W_MSK  = 6'h09;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    unique case (a[ADDR_W-1:2])
      W_DIR:   return SEL_DIR;
      W_LVL:   return SEL_LVL;
      W_HI:    return SEL_HI;
      W_LO:    return SEL_LO;
      W_IEN:   return SEL_IEN;
      W_KIND:  return SEL_KIND;
      W_POL:   return SEL_POL;
      W_PEND:  return SEL_PEND;
      W_MSK:   return SEL_MSK;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] lvl_mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);

  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = cur[i] & ~prev_q[i];
    assign fall     = ~cur[i] & prev_q[i];
    assign edge_hit = pol[i] ? rise : fall;
    assign lvl_hit  = ~(cur[i] ^ pol[i]);

    always_ff @(posedge clk) begin
      if (rst)              pend_q[i] <= 1'b0;
      else if (lvl_mode[i]) pend_q[i] <= lvl_hit;
      else                  pend_q[i] <= (pend_q[i] & ~clr[i]) | edge_hit;
    end

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !lvl_mode[i] && !clr[i]) |=> (pend_q[i] || lvl_mode[i]));

    // R7
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
      lvl_mode[i] |=> (pend_q[i] == ($past(cur[i]) == $past(pol[i]))));
  end

  assign pend = pend_q;

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int W             = 16,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [W-1:0]      sync_in,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      oe_q,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      kind_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      msk_q,
  output logic [W-1:0]      clr,
  output logic [BUS_W-1:0]  rdata
);

  localparam int PAD_W = BUS_W - W;

  reg_sel_e     sel;
  logic [W-1:0] wv;
  logic [W-1:0] dir_view;
  logic [W-1:0] oe_from_write;
  logic [W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;

  assign sel = decode_addr(bus_addr);
  assign wv  = bus_wdata[W-1:0];

  if (OE_ACTIVE_LOW) begin : g_oe_inv
    assign dir_view      = ~oe_q;
    assign oe_from_write = ~wv;
  end else begin : g_oe_norm
    assign dir_view      = oe_q;
    assign oe_from_write = wv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= '0;
      dout_q <= '0;
      ien_q  <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      msk_q  <= '0;
    end else if (bus_wr) begin
      unique case (sel)
        SEL_DIR:  oe_q   <= oe_from_write;
        SEL_HI:   dout_q <= dout_q | wv;
        SEL_LO:   dout_q <= dout_q & ~wv;
        SEL_IEN:  ien_q  <= wv;
        SEL_KIND: kind_q <= wv;
        SEL_POL:  pol_q  <= wv;
        SEL_MSK:  msk_q  <= wv;
        default:  ;
      endcase
    end
  end

  assign clr = (bus_wr && sel == SEL_PEND) ? wv : '0;

  always_comb begin
    unique case (sel)
      SEL_DIR:       rd_mux = dir_view;
      SEL_LVL:       rd_mux = sync_in;
      SEL_HI, SEL_LO: rd_mux = dout_q;
      SEL_IEN:       rd_mux = ien_q;
      SEL_KIND:      rd_mux = kind_q;
      SEL_POL:       rd_mux = pol_q;
      SEL_PEND:      rd_mux = pend;
      SEL_MSK:       rd_mux = msk_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= {{PAD_W{1'b0}}, rd_mux};
  end

  assign rdata = rdata_q;

  // R2
  set_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_HI) |=> ((dout_q & $past(wv)) == $past(wv)));

  // R2
  clear_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_LO) |=> ((dout_q & $past(wv)) == '0));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rdata[BUS_W-1:W] == '0));

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS      = 16,
  parameter bit OE_ACTIVE_LOW = 1'b0,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  logic [NUM_PINS-1:0] sync_in;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] ien, kind, pol, msk, clr;
  logic                irq_q;

  pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_in)
  );

  pin_irq_regs #(.W(NUM_PINS), .OE_ACTIVE_LOW(OE_ACTIVE_LOW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .sync_in   (sync_in),
    .pend      (pend),
    .oe_q      (pin_oe),
    .dout_q    (pin_out),
    .ien_q     (ien),
    .kind_q    (kind),
    .pol_q     (pol),
    .msk_q     (msk),
    .clr       (clr),
    .rdata     (bus_rdata)
  );

  pin_irq_detect #(.W(NUM_PINS)) u_det (
    .clk      (clk),
    .rst      (rst),
    .cur      (sync_in),
    .lvl_mode (kind),
    .pol      (pol),
    .clr      (clr),
    .pend     (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend & ien & msk);
  end

  assign irq = irq_q;

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (msk == '0 || ien == '0) |=> !irq);

  // R8
  armed_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & ien & msk) != '0) |=> irq);

endmodule

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;

  localparam int N = 16;
  localparam logic [31:0] NM = (32'h1 << N) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [N-1:0] pin_in = '0;
  logic [31:0] rdata, rdata_i;
  logic [N-1:0] pin_out, pin_oe, pin_out_i, pin_oe_i;
  logic        irq, irq_i;

  always #4 clk = ~clk;

  pin_irq_ctrl #(.NUM_PINS(N), .OE_ACTIVE_LOW(1'b0)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  pin_irq_ctrl #(.NUM_PINS(N), .OE_ACTIVE_LOW(1'b1)) uut_inv (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_i), .pin_in(pin_in),
    .pin_out(pin_out_i), .pin_oe(pin_oe_i), .irq(irq_i));

  int checks = 0;
  int failures = 0;

  // behavioural model state
  logic [31:0] m_s1, m_s2, m_prev, m_pend, m_oe, m_oei, m_dout;
  logic [31:0] m_ien, m_kind, m_pol, m_msk, m_rd, m_rdi;
  logic        m_irq;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a, input bit inv);
    case (a[7:2])
      6'h00: return inv ? (~m_oei & NM) : m_oe;
      6'h01: return m_s2;
      6'h03, 6'h04: return m_dout;
      6'h05: return m_ien;
      6'h06: return m_kind;
      6'h07: return m_pol;
      6'h08: return m_pend;
      6'h09: return m_msk;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a[7:2])
      6'h00: return "R10/R3";
      6'h01: return "R10/R4";
      6'h03, 6'h04: return "R10/R2";
      6'h05, 6'h09: return "R10/R8";
      6'h06, 6'h07: return "R10/R5";
      6'h08: return "R10/R6/R7";
      default: return "R10/R9";
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] wv, np;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_oe = 0; m_oei = 0;
      m_dout = 0; m_ien = 0; m_kind = 0; m_pol = 0; m_msk = 0;
      m_rd = 0; m_rdi = 0; m_irq = 0;
      return;
    end
    wv = bus_wdata & NM;
    m_rd  = model_read(bus_addr, 1'b0);
    m_rdi = model_read(bus_addr, 1'b1);
    m_irq = ((m_pend & m_ien & m_msk) != 0);
    np = m_pend;
    for (int b = 0; b < N; b++) begin
      if (m_kind[b]) np[b] = (m_s2[b] == m_pol[b]);
      else begin
        if (bus_wr && bus_addr[7:2] == 6'h08 && wv[b]) np[b] = 1'b0;
        if (m_pol[b] && m_s2[b] && !m_prev[b]) np[b] = 1'b1;
        if (!m_pol[b] && !m_s2[b] && m_prev[b]) np[b] = 1'b1;
      end
    end
    m_pend = np;
    m_prev = m_s2;
    m_s2 = m_s1;
    m_s1 = 32'(pin_in);
    if (bus_wr) begin
      case (bus_addr[7:2])
        6'h00: begin m_oe = wv; m_oei = ~wv & NM; end
        6'h03: m_dout = m_dout | wv;
        6'h04: m_dout = m_dout & ~wv;
        6'h05: m_ien = wv;
        6'h06: m_kind = wv;
        6'h07: m_pol = wv;
        6'h09: m_msk = wv;
        default: ;
      endcase
    end
  endtask

  logic [7:0] last_addr;

  task automatic tick(input logic [7:0] a, input logic w, input logic [31:0] d);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    last_addr = a;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(rd_tag(last_addr), rdata, m_rd);
    check(rd_tag(last_addr), rdata_i, m_rdi);
    check("R2 pin_out", 32'(pin_out), m_dout);
    check("R3 pin_oe", 32'(pin_oe), m_oe);
    check("R3 pin_oe inverted", 32'(pin_oe_i), m_oei);
    check("R8 irq", 32'(irq), 32'(m_irq));
    check("R8 irq inverted", 32'(irq_i), 32'(m_irq));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(8'h28, 1'b0, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    rst = 1'b1;
    tick(8'h00, 1'b0, 0); tick(8'h00, 1'b0, 0);
    rst = 1'b0;
    // R1: reset values
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 pin_oe inverted", 32'(pin_oe_i), 0);
    check("R1 irq", 32'(irq), 0);
    tick(8'h00, 1'b0, 0);
    check("R1 dir read inverted", rdata_i, NM);
    tick(8'h20, 1'b0, 0);
    check("R1 pending read", rdata, 0);

    // R2: set then clear, read back both offsets
    tick(8'h0C, 1'b1, 32'hFFFF_00A5);
    tick(8'h10, 1'b1, 32'h0000_0005);
    check("R2 pin_out after set/clear", 32'(pin_out), 32'h0000_00A0);
    tick(8'h0C, 1'b0, 0);
    tick(8'h10, 1'b0, 0);
    check("R2 read clear offset", rdata, 32'h0000_00A0);

    // R3 and R9: direction register, upper bits dropped
    tick(8'h00, 1'b1, 32'hFFFF_F00F);
    tick(8'h00, 1'b0, 0);
    check("R9 dir read masked", rdata, 32'h0000_F00F);
    check("R3 inverted pin_oe", 32'(pin_oe_i), 32'h0000_0FF0);

    // R4: synchroniser latency
    pin_in = 16'h1234;
    tick(8'h04, 1'b0, 0);
    tick(8'h04, 1'b0, 0);
    check("R4 input not yet visible", rdata, 0);
    tick(8'h04, 1'b0, 0);
    check("R4 input visible", rdata, 32'h1234);
    pin_in = '0;
    idle(4);

    // R5/R6/R8: rising edge on pin 0, then clear
    tick(8'h1C, 1'b1, 32'h0000_0003);
    tick(8'h18, 1'b1, 32'h0000_0000);
    tick(8'h14, 1'b1, 32'h0000_0003);
    tick(8'h24, 1'b1, 32'h0000_0003);
    idle(3);
    pin_in[0] = 1'b1;
    idle(4);
    check("R8 irq after edge", 32'(irq), 1);
    tick(8'h20, 1'b1, 32'h1);
    idle(2);
    check("R6 cleared, irq low", 32'(irq), 0);

    // R6: edge on pin 1 collides with its clearing write
    pin_in[1] = 1'b1;
    idle(2);
    tick(8'h20, 1'b1, 32'h2);
    tick(8'h20, 1'b0, 0);
    check("R6 set wins over clear", rdata & 32'h2, 32'h2);
    tick(8'h20, 1'b1, 32'h2);

    // R7: level-low on pin 2, clearing write ignored
    tick(8'h18, 1'b1, 32'h4);
    idle(2);
    tick(8'h20, 1'b1, 32'h4);
    tick(8'h20, 1'b0, 0);
    check("R7 level pending held", rdata & 32'h4, 32'h4);
    pin_in[2] = 1'b1;
    idle(3);
    tick(8'h20, 1'b0, 0);
    check("R7 level pending dropped", rdata & 32'h4, 0);

    // R8: enable set but mask clear keeps irq low
    tick(8'h14, 1'b1, 32'h4);
    tick(8'h24, 1'b1, 32'h0);
    pin_in[2] = 1'b0;
    idle(5);
    check("R8 masked irq", 32'(irq), 0);

    // random phase: all offsets, random pins
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      int pick;
      pick = int'($urandom_range(0, 10));
      case (pick)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h0C; 3: a = 8'h10;
        4: a = 8'h14; 5: a = 8'h18; 6: a = 8'h1C; 7: a = 8'h20;
        8: a = 8'h24; 9: a = 8'h08; default: a = 8'h28;
      endcase
      if ($urandom_range(0, 3) == 0) pin_in = N'($urandom);
      tick(a, 1'($urandom_range(0, 1)), $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule